// File: doc/BRIEF.md
# Dual-Processor Doorbell Exchange

This block lets two processors signal each other without shared memory. Each processor has its own register port, made up of an address, a write strobe, write data and combinational read data, and its own interrupt line. Each side owns a 15-bit doorbell status word and a 15-bit interrupt enable word.

A side rings the other side by writing ones to its ring register. Those bits become set in the remote side's status word. The only way to clear a status bit is a write-one-to-clear write from the side that owns it. Each side can also read a read-only copy of the other side's enable mask. This lets a sender check whether a doorbell it raises will actually interrupt the receiver.

Each side's interrupt is the registered OR of its own status bits masked by its own enables.

Top module: `doorbell_xchg`

## Requirements
- R1: After reset, every status and enable bit is 0, both interrupts are 0, and every readable offset returns 0 on both ports.
- R2: A write to the ring register (offset 0x0A10) sets, from the next cycle on, the remote status bits that match ones in write data bits [14:0]. Zero bits and bits [31:15] change nothing.
- R3: The status register (offset 0x0A08) reads the local status in bits [14:0] with bits [31:15] at 0. A write by its owner clears the bits written as 1 and leaves the bits written as 0 unchanged.
- R4: No write from the remote port clears a local status bit. This includes a ring write of zeros and writes to any other offset.
- R5: The enable register (offset 0x0A0C) is read/write on bits [14:0]. Bits [31:15] read as 0.
- R6: The peer-mask register (offset 0x0A14) returns the remote side's current enable mask in bits [14:0]. Writes to it have no effect.
- R7: Reading the ring register returns 0. Any other unmapped offset reads 0, and writes to it have no effect.
- R8: A side's interrupt equals the OR of (status AND enable) as it stood one cycle earlier.
- R9: When a remote ring and a local clear target the same status bit in the same cycle, the bit ends up set.
- R10: Ring writes from both ports in the same cycle each update only the opposite side's status, independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| a_addr | input | 12 | Side A register address |
| a_wr | input | 1 | Side A write strobe |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data (combinational) |
| a_irq | output | 1 | Side A doorbell interrupt |
| b_addr | input | 12 | Side B register address |
| b_wr | input | 1 | Side B write strobe |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data (combinational) |
| b_irq | output | 1 | Side B doorbell interrupt |

## Verification
The bench targets these corner cases:

- **Set and clear on the same bit in one cycle.** A design that lets the clear win would silently lose a doorbell.
- **Both sides ringing in the same cycle.** A design that crosses or merges the two paths would set bits on the wrong side.
- **Ring writes of zeros, and writes to the peer-mask offset.** A design that treats the ring register as a plain load would let the sender erase the receiver's pending bits.
- **Interrupt timing.** The interrupt must follow status and enable exactly one cycle late; a design that is combinational or two cycles late would miss the per-cycle comparison.

A long mixed phase of pseudo-random accesses from both ports is compared against the reference model on every clock.

// File: rtl/db_pkg.sv
package db_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_STAT = 12'hA08;
  localparam logic [ADDR_W-1:0] OFF_EN   = 12'hA0C;
  localparam logic [ADDR_W-1:0] OFF_RING = 12'hA10;
  localparam logic [ADDR_W-1:0] OFF_PEER = 12'hA14;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_EN,
    SEL_RING,
    SEL_PEER
  } db_sel_e;

  function automatic db_sel_e decode_sel(input logic [ADDR_W-1:0] a);
    case (a)
      OFF_STAT: return SEL_STAT;
      OFF_EN:   return SEL_EN;
      OFF_RING: return SEL_RING;
      OFF_PEER: return SEL_PEER;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/db_port_if.sv
module db_port_if
  import db_pkg::*;
#(
  parameter int DB_W   = 15,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DB_W-1:0]   loc_stat,
  input  logic [DB_W-1:0]   loc_en,
  input  logic [DB_W-1:0]   rem_en,
  output logic [DB_W-1:0]   clr_vec,
  output logic              en_we,
  output logic [DB_W-1:0]   en_wdata,
  output logic [DB_W-1:0]   ring_vec,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - DB_W;

  db_sel_e   sel;
  logic [DB_W-1:0] rd_field;

  assign sel      = decode_sel(addr);
  assign clr_vec  = (wr && sel == SEL_STAT) ? wdata[DB_W-1:0] : '0;
  assign ring_vec = (wr && sel == SEL_RING) ? wdata[DB_W-1:0] : '0;
  assign en_we    = wr && sel == SEL_EN;
  assign en_wdata = wdata[DB_W-1:0];

  always_comb begin
    case (sel)
      SEL_STAT: rd_field = loc_stat;
      SEL_EN:   rd_field = loc_en;
      SEL_PEER: rd_field = rem_en;
      default:  rd_field = '0;
    endcase
  end

  assign rdata = {{PAD_W{1'b0}}, rd_field};

  // R7
  ring_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr == OFF_RING |-> rdata == '0);

  // R2
  upper_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFF_RING && wdata[DATA_W-1:DB_W] != '0) |-> ring_vec == wdata[DB_W-1:0]);
endmodule

// File: rtl/db_side_state.sv
module db_side_state #(
  parameter int DB_W = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DB_W-1:0] clr_vec,
  input  logic [DB_W-1:0] set_vec,
  input  logic            en_we,
  input  logic [DB_W-1:0] en_wdata,
  output logic [DB_W-1:0] stat,
  output logic [DB_W-1:0] en,
  output logic            irq
);
  function automatic logic [DB_W-1:0] merge_bits(input logic [DB_W-1:0] old_v,
                                                 input logic [DB_W-1:0] clr_v,
                                                 input logic [DB_W-1:0] set_v);
    return (old_v & ~clr_v) | set_v;
  endfunction

  function automatic logic pending(input logic [DB_W-1:0] s, input logic [DB_W-1:0] e);
    return |(s & e);
  endfunction

  logic [DB_W-1:0] stat_nx;
  logic [DB_W-1:0] collide;

  assign stat_nx = merge_bits(stat, clr_vec, set_vec);
  assign collide = clr_vec & set_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
      en   <= '0;
      irq  <= 1'b0;
    end else begin
      stat <= stat_nx;
      if (en_we) en <= en_wdata;
      irq  <= pending(stat, en);
    end
  end

  // R2
  ring_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec != '0 |=> (stat & $past(set_vec)) == $past(set_vec));

  // R4
  owner_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat) & ~stat) & ~$past(clr_vec)) == '0);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    collide != '0 |=> (stat & $past(collide)) == $past(collide));

  // R5
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> en == $past(en_wdata));

  // R8
  irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(|(stat & en)));
endmodule

// File: rtl/doorbell_xchg.sv
module doorbell_xchg
  import db_pkg::*;
#(
  parameter int DB_W   = 15,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       a_addr,
  input  logic              a_wr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_irq,
  input  logic [11:0]       b_addr,
  input  logic              b_wr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_irq
);
  localparam int SIDES = 2;

  logic [ADDR_W-1:0] addr_s  [SIDES];
  logic              wr_s    [SIDES];
  logic [DATA_W-1:0] wdata_s [SIDES];
  logic [DATA_W-1:0] rdata_s [SIDES];
  logic              irq_s   [SIDES];
  logic [DB_W-1:0]   stat_s  [SIDES];
  logic [DB_W-1:0]   en_s    [SIDES];
  logic [DB_W-1:0]   clr_s   [SIDES];
  logic [DB_W-1:0]   ring_s  [SIDES];
  logic              enwe_s  [SIDES];
  logic [DB_W-1:0]   enwd_s  [SIDES];

  assign addr_s[0]  = a_addr;
  assign wr_s[0]    = a_wr;
  assign wdata_s[0] = a_wdata;
  assign addr_s[1]  = b_addr;
  assign wr_s[1]    = b_wr;
  assign wdata_s[1] = b_wdata;
  assign a_rdata    = rdata_s[0];
  assign a_irq      = irq_s[0];
  assign b_rdata    = rdata_s[1];
  assign b_irq      = irq_s[1];

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    localparam int PEER = SIDES - 1 - s;

    db_port_if #(.DB_W(DB_W), .DATA_W(DATA_W)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (addr_s[s]),
      .wr       (wr_s[s]),
      .wdata    (wdata_s[s]),
      .loc_stat (stat_s[s]),
      .loc_en   (en_s[s]),
      .rem_en   (en_s[PEER]),
      .clr_vec  (clr_s[s]),
      .en_we    (enwe_s[s]),
      .en_wdata (enwd_s[s]),
      .ring_vec (ring_s[s]),
      .rdata    (rdata_s[s])
    );

    db_side_state #(.DB_W(DB_W)) u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_vec  (clr_s[s]),
      .set_vec  (ring_s[PEER]),
      .en_we    (enwe_s[s]),
      .en_wdata (enwd_s[s]),
      .stat     (stat_s[s]),
      .en       (en_s[s]),
      .irq      (irq_s[s])
    );
  end
endmodule

// File: tb/doorbell_xchg_tb_top.sv
module doorbell_xchg_tb_top;
  localparam int MASK = 32'h7FFF;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [11:0] addr_v [2];
  logic        wr_v   [2];
  logic [31:0] wd_v   [2];
  logic [31:0] a_rdata, b_rdata;
  logic        a_irq, b_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  int m_st [2];
  int m_en [2];
  int m_irq [2];

  always #4 clk = ~clk;

  doorbell_xchg dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_addr(addr_v[0]), .a_wr(wr_v[0]), .a_wdata(wd_v[0]), .a_rdata(a_rdata), .a_irq(a_irq),
    .b_addr(addr_v[1]), .b_wr(wr_v[1]), .b_wdata(wd_v[1]), .b_rdata(b_rdata), .b_irq(b_irq)
  );

  function automatic int model_read(int s, logic [11:0] a);
    case (a)
      12'hA08: return m_st[s];
      12'hA0C: return m_en[s];
      12'hA14: return m_en[1-s];
      default: return 0;
    endcase
  endfunction

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("a_rdata", int'(a_rdata), model_read(0, addr_v[0]));
    check("b_rdata", int'(b_rdata), model_read(1, addr_v[1]));
    check("a_irq", int'(a_irq), m_irq[0]);
    check("b_irq", int'(b_irq), m_irq[1]);
  endtask

  task automatic cyc();
    int clr [2];
    int setv [2];
    @(posedge clk);
    if (!rst_n) begin
      for (int s = 0; s < 2; s++) begin
        m_st[s] = 0; m_en[s] = 0; m_irq[s] = 0;
      end
    end else begin
      for (int s = 0; s < 2; s++) begin
        clr[s]  = (wr_v[s] && addr_v[s] == 12'hA08) ? (int'(wd_v[s]) & MASK) : 0;
        setv[s] = (wr_v[1-s] && addr_v[1-s] == 12'hA10) ? (int'(wd_v[1-s]) & MASK) : 0;
      end
      for (int s = 0; s < 2; s++) begin
        m_irq[s] = ((m_st[s] & m_en[s]) != 0) ? 1 : 0;
        m_st[s]  = (m_st[s] & ~clr[s]) | setv[s];
        if (wr_v[s] && addr_v[s] == 12'hA0C) m_en[s] = int'(wd_v[s]) & MASK;
      end
    end
    @(negedge clk);
    if (rst_n) compare_all();
  endtask

  task automatic idle();
    for (int s = 0; s < 2; s++) begin
      wr_v[s] = 0; wd_v[s] = 0;
    end
  endtask

  task automatic put(int s, logic [11:0] a, logic w, logic [31:0] d);
    addr_v[s] = a; wr_v[s] = w; wd_v[s] = d;
  endtask

  task automatic op(int s, logic [11:0] a, logic w, logic [31:0] d);
    idle();
    put(s, a, w, d);
    cyc();
    idle();
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    idle();
    addr_v[0] = 0; addr_v[1] = 0;
    for (int s = 0; s < 2; s++) begin
      m_st[s] = 0; m_en[s] = 0; m_irq[s] = 0;
    end
    repeat (3) cyc();
    rst_n = 1;

    // R1: reset values on every offset
    cur_req = "R1";
    for (int k = 0; k < 5; k++) begin
      logic [11:0] a;
      a = (k == 4) ? 12'h000 : 12'hA08 + 12'(4 * k);
      put(0, a, 0, 0); put(1, a, 0, 0);
      cyc();
    end

    // R5: enable load, upper bits ignored
    cur_req = "R5";
    op(0, 12'hA0C, 1, 32'hFFFF_0005);
    op(0, 12'hA0C, 0, 0);

    // R6: peer mask visible, writes ignored
    cur_req = "R6";
    op(1, 12'hA14, 0, 0);
    op(1, 12'hA14, 1, 32'h7FFF);
    op(1, 12'hA14, 0, 0);

    // R2: ring with upper bits set
    cur_req = "R2";
    op(1, 12'hA10, 1, 32'hABCD_0001);
    op(0, 12'hA08, 0, 0);

    // R8: interrupt one cycle after status
    cur_req = "R8";
    op(0, 12'hA08, 0, 0);
    op(0, 12'hA0C, 1, 32'h0);
    op(0, 12'hA0C, 1, 32'h1);
    op(0, 12'hA08, 0, 0);

    // R3: owner clears with ones only
    cur_req = "R3";
    op(1, 12'hA10, 1, 32'h0000_0F0F);
    op(0, 12'hA08, 1, 32'hFFFF_0003);
    op(0, 12'hA08, 0, 0);

    // R4: remote cannot clear
    cur_req = "R4";
    op(0, 12'hA10, 1, 32'h0000_1234);
    op(0, 12'hA10, 1, 32'h0);
    op(0, 12'hA14, 1, 32'h7FFF);
    op(0, 12'hA08, 1, 32'h7FFF);
    op(1, 12'hA08, 0, 0);

    // R7: ring reads zero, unmapped offsets inert
    cur_req = "R7";
    op(1, 12'hA10, 0, 0);
    op(1, 12'h123, 1, 32'hFFFF_FFFF);
    op(1, 12'hA08, 0, 0);
    op(0, 12'h123, 0, 0);

    // R9: set beats a same-cycle clear
    cur_req = "R9";
    idle();
    put(0, 12'hA08, 1, 32'h0000_0008);
    put(1, 12'hA10, 1, 32'h0000_0008);
    cyc();
    idle();
    op(0, 12'hA08, 0, 0);

    // R10: both sides ring together
    cur_req = "R10";
    idle();
    put(0, 12'hA10, 1, 32'h0000_4000);
    put(1, 12'hA10, 1, 32'h0000_0100);
    cyc();
    idle();
    put(0, 12'hA08, 0, 0); put(1, 12'hA08, 0, 0);
    cyc();

    // R2: mixed traffic from both ports
    cur_req = "R2";
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      for (int s = 0; s < 2; s++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        addr_v[s] = 12'hA08 + 12'(4 * (lfsr[2:0] % 5));
        wr_v[s]   = lfsr[5];
        wd_v[s]   = {lfsr, lfsr[7:0], lfsr[15:8]};
      end
      cyc();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule